// File: doc/BRIEF.md
# NAND Read-Retry Command Sequencer

This block produces the ordered bus cycles that a NAND flash controller needs for two maintenance flows. The retry flow moves the device into a chosen read-retry mode: it opens the vendor parameter mode, writes one value into each of a fixed list of internal device registers, and then commits the new settings. The parameter flow opens the one-time-programmable parameter area, reads one page of it, and puts the device back into normal operation.

The bus side is abstract. Each cycle is presented as a kind (command, address, data-out, page read or reset) with its byte, or its page number and length, and is held until the bus interface accepts it with a ready pulse. The bus interface may report an error with that ready pulse, and the sequence then stops. A request port starts a flow and selects the mode or the parameter page. The block reports busy while a flow runs and raises a one-cycle done pulse with an error flag and a code when the flow ends.

Top module: `rr_cmd_seq`

## Requirements
- R1: A retry request with an in-range mode issues exactly 2+2*NREGS cycles: command 0x36, then NREGS address/data-out pairs, then command 0x16.
- R2: The address bytes of the retry pairs follow this order of device register offsets: 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R3: The data-out byte that follows the address of register index i in mode m is ((m*16)+i) XOR 0xA5, truncated to 8 bits.
- R4: A parameter-area request first issues: reset, command 0x36, address 0x38, data-out 0x52, command 0x16, then commands 0x17, 0x04 and 0x19 in that order.
- R5: After that opening, one page read from column 0 follows: page 0x21F with length 784 when the page select is 0, page 0x200 with length 528 when it is 1.
- R6: The parameter-area flow closes with: reset, command 0x36, address 0x38, data-out 0x00, command 0x16, then a page read of page 0 with length 0 (15 cycles in the whole flow).
- R7: Each cycle keeps bus_valid high and its kind, byte, page and length unchanged until the cycle in which bus_ready is high; kind codes are 0 command, 1 address, 2 data-out, 3 page read, 4 reset; a reset carries byte 0xFF, a page read carries byte 0x00, and all non-page cycles carry page 0 and length 0.
- R8: When bus_ready arrives with bus_err high, no further cycle is issued, and done pulses with done_err high and done_code equal to bus_err_code from that handshake.
- R9: busy is high from the cycle after an accepted start until done; done is a one-cycle pulse during which busy is low; a flow without error ends with done_err low and done_code 0.
- R10: A start request while busy is ignored: the running flow's cycles continue unchanged and no second flow follows.
- R11: A retry request with a mode number of NMODES or more issues no bus cycle and pulses done in the next cycle with done_err high and done_code 0xF.
- R12: During and right after reset, busy, done and bus_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start pulse, sampled while idle |
| req_flow | input | 1 | 0 retry flow, 1 parameter-area flow |
| req_mode | input | MODE_W | Retry mode number |
| req_otp_sel | input | 1 | Parameter page select |
| busy | output | 1 | A flow is running |
| done | output | 1 | One-cycle end-of-flow pulse |
| done_err | output | 1 | The flow ended on an error |
| done_code | output | 4 | Error code, 0 on success |
| bus_valid | output | 1 | A bus cycle is presented |
| bus_kind | output | 3 | Cycle kind code |
| bus_byte | output | 8 | Command, address or data byte |
| bus_page | output | 16 | Page number of a page read |
| bus_len | output | 16 | Byte count of a page read |
| bus_ready | input | 1 | Bus interface accepts the cycle |
| bus_err | input | 1 | The accepted cycle failed |
| bus_err_code | input | 4 | Code of the failure |

## Verification
The assertions take for granted that bus_ready is only raised while bus_valid is high, that bus_err and bus_err_code only mean something together with bus_ready, and that req_mode, req_flow and req_otp_sel are stable in the cycle req_start is high. The bench's bus model raises ready only after it has seen bus_valid, with stalls of zero to two cycles, and raises bus_err only in the same cycle as ready. Request fields are driven together with the start pulse, and the extra start during a running flow uses a different flow so that any effect would show on the bus.

// File: rtl/rr_seq_pkg.sv
// Shared types and constants of the read-retry command sequencer.
// Assumes the device register list holds at most eight entries.
package rr_seq_pkg;

    typedef enum logic [2:0] {
        BK_CMD   = 3'd0,
        BK_ADDR  = 3'd1,
        BK_DOUT  = 3'd2,
        BK_PAGE  = 3'd3,
        BK_RESET = 3'd4
    } bus_kind_e;

    localparam logic [7:0] OP_PARAM_OPEN  = 8'h36;
    localparam logic [7:0] OP_PARAM_DONE  = 8'h16;
    localparam logic [7:0] OP_AREA_STEP1  = 8'h17;
    localparam logic [7:0] OP_AREA_STEP2  = 8'h04;
    localparam logic [7:0] OP_AREA_STEP3  = 8'h19;
    localparam logic [7:0] AREA_CTRL_REG  = 8'h38;
    localparam logic [7:0] AREA_OPEN_VAL  = 8'h52;
    localparam logic [7:0] AREA_CLOSE_VAL = 8'h00;
    localparam logic [7:0] RESET_BYTE     = 8'hFF;
    localparam logic [3:0] CODE_BAD_MODE  = 4'hF;

    // Device register offset for list position idx.
    function automatic logic [7:0] retry_reg_offset(input int unsigned idx);
        case (idx)
            0:       return 8'hCC;
            1:       return 8'hBF;
            2:       return 8'hAA;
            3:       return 8'hAB;
            4:       return 8'hCD;
            5:       return 8'hAD;
            6:       return 8'hAE;
            7:       return 8'hAF;
            default: return 8'h00;
        endcase
    endfunction

    // Built-in parameter value for mode m, register position i.
    function automatic logic [7:0] retry_value(input int unsigned m, input int unsigned i);
        logic [31:0] raw;
        raw = ((m * 16) + i) ^ 32'hA5;
        return raw[7:0];
    endfunction

endpackage

// File: rtl/rr_param_table.sv
// Parameter table: holds the device register offsets and one row of
// values per retry mode, and looks up one (offset, value) pair.
// Assumes NREGS <= 8; an out-of-range mode reads as zero.
module rr_param_table
    import rr_seq_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int NMODES = 6,
    parameter int MODE_W = 3,
    parameter int REG_W  = 3
) (
    input  logic [MODE_W-1:0] mode_idx,
    input  logic [REG_W-1:0]  reg_idx,
    output logic [7:0]        reg_off,
    output logic [7:0]        reg_val
);
    localparam int ENTRIES = NREGS * NMODES;

    logic [7:0] offs [NREGS];
    logic [7:0] vals [ENTRIES];

    // Fill the offset list and the value rows.
    for (genvar r = 0; r < NREGS; r++) begin : g_off
        assign offs[r] = retry_reg_offset(r);
        for (genvar m = 0; m < NMODES; m++) begin : g_val
            assign vals[m*NREGS + r] = retry_value(m, r);
        end
    end

    // Select the entry of the requested mode row.
    always_comb begin
        reg_off = 8'h00;
        reg_val = 8'h00;
        if (int'(reg_idx) < NREGS) begin
            reg_off = offs[reg_idx];
            if (int'(mode_idx) < NMODES) begin
                reg_val = vals[int'(mode_idx)*NREGS + int'(reg_idx)];
            end
        end
    end

endmodule

// File: rtl/rr_step_decode.sv
// Step decoder: maps (flow, step number) to one bus cycle description.
// Assumes step stays within the length of the selected flow.
module rr_step_decode
    import rr_seq_pkg::*;
#(
    parameter int          NREGS     = 8,
    parameter int          STEP_W    = 5,
    parameter int          REG_W     = 3,
    parameter logic [15:0] PAGE_SEL0 = 16'h021F,
    parameter logic [15:0] LEN_SEL0  = 16'd784,
    parameter logic [15:0] PAGE_SEL1 = 16'h0200,
    parameter logic [15:0] LEN_SEL1  = 16'd528
) (
    input  logic              flow_area,
    input  logic              page_sel,
    input  logic [STEP_W-1:0] step,
    input  logic [7:0]        reg_off,
    input  logic [7:0]        reg_val,
    output logic [REG_W-1:0]  reg_idx,
    output logic [2:0]        kind,
    output logic [7:0]        byte_o,
    output logic [15:0]       page,
    output logic [15:0]       len,
    output logic              last
);
    localparam int RETRY_LAST = 2 * NREGS + 1;
    localparam int AREA_LAST  = 14;

    logic [STEP_W-1:0] pair_pos;

    // Position within the address/data pairs of the retry flow.
    always_comb begin
        pair_pos = step - STEP_W'(1);
        reg_idx  = pair_pos[REG_W:1];
    end

    // Decode the cycle for the current step.
    always_comb begin
        kind   = BK_CMD;
        byte_o = 8'h00;
        page   = 16'h0000;
        len    = 16'h0000;
        last   = 1'b0;
        if (!flow_area) begin
            if (step == '0) begin
                byte_o = OP_PARAM_OPEN;
            end else if (int'(step) == RETRY_LAST) begin
                byte_o = OP_PARAM_DONE;
                last   = 1'b1;
            end else if (!pair_pos[0]) begin
                kind   = BK_ADDR;
                byte_o = reg_off;
            end else begin
                kind   = BK_DOUT;
                byte_o = reg_val;
            end
        end else begin
            case (int'(step))
                0, 9: begin kind = BK_RESET; byte_o = RESET_BYTE; end
                1, 10: byte_o = OP_PARAM_OPEN;
                2, 11: begin kind = BK_ADDR; byte_o = AREA_CTRL_REG; end
                3: begin kind = BK_DOUT; byte_o = AREA_OPEN_VAL; end
                12: begin kind = BK_DOUT; byte_o = AREA_CLOSE_VAL; end
                4, 13: byte_o = OP_PARAM_DONE;
                5: byte_o = OP_AREA_STEP1;
                6: byte_o = OP_AREA_STEP2;
                7: byte_o = OP_AREA_STEP3;
                8: begin
                    kind = BK_PAGE;
                    page = page_sel ? PAGE_SEL1 : PAGE_SEL0;
                    len  = page_sel ? LEN_SEL1 : LEN_SEL0;
                end
                default: begin
                    kind = BK_PAGE;
                    last = (int'(step) == AREA_LAST);
                end
            endcase
        end
    end

endmodule

// File: rtl/rr_cmd_seq.sv
// Read-retry command sequencer top: accepts a request, steps through the
// selected flow one handshaken bus cycle at a time, aborts on a bus error
// and reports completion. Assumes bus_ready only while bus_valid is high.
module rr_cmd_seq
    import rr_seq_pkg::*;
#(
    parameter int          NREGS     = 8,
    parameter int          NMODES    = 6,
    parameter int          MODE_W    = 3,
    parameter logic [15:0] PAGE_SEL0 = 16'h021F,
    parameter logic [15:0] LEN_SEL0  = 16'd784,
    parameter logic [15:0] PAGE_SEL1 = 16'h0200,
    parameter logic [15:0] LEN_SEL1  = 16'd528
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_flow,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_otp_sel,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic [3:0]        done_code,
    output logic              bus_valid,
    output logic [2:0]        bus_kind,
    output logic [7:0]        bus_byte,
    output logic [15:0]       bus_page,
    output logic [15:0]       bus_len,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [3:0]        bus_err_code
);
    localparam int REG_W     = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int MAX_STEPS = (2 * NREGS + 2 > 15) ? 2 * NREGS + 2 : 15;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    typedef enum logic { S_IDLE, S_ISSUE } seq_state_e;

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic              flow_q;
    logic              sel_q;
    logic [MODE_W-1:0] mode_q;
    logic              done_q;
    logic              derr_q;
    logic [3:0]        dcode_q;

    logic [REG_W-1:0]  reg_idx;
    logic [7:0]        reg_off;
    logic [7:0]        reg_val;
    logic              step_last;
    logic              mode_bad;
    logic              accept;

    rr_param_table #(
        .NREGS (NREGS),
        .NMODES(NMODES),
        .MODE_W(MODE_W),
        .REG_W (REG_W)
    ) table_i (
        .mode_idx(mode_q),
        .reg_idx (reg_idx),
        .reg_off (reg_off),
        .reg_val (reg_val)
    );

    rr_step_decode #(
        .NREGS    (NREGS),
        .STEP_W   (STEP_W),
        .REG_W    (REG_W),
        .PAGE_SEL0(PAGE_SEL0),
        .LEN_SEL0 (LEN_SEL0),
        .PAGE_SEL1(PAGE_SEL1),
        .LEN_SEL1 (LEN_SEL1)
    ) decode_i (
        .flow_area(flow_q),
        .page_sel (sel_q),
        .step     (step_q),
        .reg_off  (reg_off),
        .reg_val  (reg_val),
        .reg_idx  (reg_idx),
        .kind     (bus_kind),
        .byte_o   (bus_byte),
        .page     (bus_page),
        .len      (bus_len),
        .last     (step_last)
    );

    // Request checks and handshake detection.
    always_comb begin
        mode_bad = !req_flow && ({1'b0, req_mode} >= (MODE_W+1)'(NMODES));
        accept   = (state_q == S_ISSUE) && bus_ready;
    end

    // Sequencer state, step counter and completion status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            flow_q  <= 1'b0;
            sel_q   <= 1'b0;
            mode_q  <= '0;
            done_q  <= 1'b0;
            derr_q  <= 1'b0;
            dcode_q <= 4'h0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_start) begin
                        if (mode_bad) begin
                            done_q  <= 1'b1;
                            derr_q  <= 1'b1;
                            dcode_q <= CODE_BAD_MODE;
                        end else begin
                            state_q <= S_ISSUE;
                            step_q  <= '0;
                            flow_q  <= req_flow;
                            sel_q   <= req_otp_sel;
                            mode_q  <= req_mode;
                            derr_q  <= 1'b0;
                            dcode_q <= 4'h0;
                        end
                    end
                end
                default: begin
                    if (accept) begin
                        if (bus_err) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            derr_q  <= 1'b1;
                            dcode_q <= bus_err_code;
                        end else if (step_last) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Output drive.
    always_comb begin
        busy      = (state_q == S_ISSUE);
        bus_valid = (state_q == S_ISSUE);
        done      = done_q;
        done_err  = derr_q;
        done_code = dcode_q;
    end

    // A presented cycle stays unchanged until accepted.
    p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_kind) && $stable(bus_byte)
            && $stable(bus_page) && $stable(bus_len));

    // An errored handshake ends the flow with the error reported.
    p_error_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready && bus_err |=> !bus_valid && done && done_err
            && (done_code == $past(bus_err_code)));

    // done is a single pulse outside busy.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);

    // A start while running does not change the latched request.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_start && !bus_ready |=> busy && $stable(flow_q) && $stable(step_q)
            && $stable(mode_q));

    // A rejected mode produces no bus cycle.
    p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_start && mode_bad |=> !bus_valid && done && (done_code == CODE_BAD_MODE));

    // The retry flow opens with the parameter-open command.
    p_retry_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_start && !req_flow && !mode_bad |=> bus_valid
            && (bus_kind == BK_CMD) && (bus_byte == OP_PARAM_OPEN));

endmodule

// File: tb/rr_cmd_seq_tb_top.sv
// Scoreboard bench: driver tasks queue the expected bus cycles, the bus
// model pops and compares them as the design presents them.
module rr_cmd_seq_tb_top;
    localparam int NREGS  = 8;
    localparam int NMODES = 6;
    localparam int MODE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_start = 1'b0;
    logic              req_flow = 1'b0;
    logic [MODE_W-1:0] req_mode = '0;
    logic              req_otp_sel = 1'b0;
    logic              busy, done, done_err;
    logic [3:0]        done_code;
    logic              bus_valid;
    logic [2:0]        bus_kind;
    logic [7:0]        bus_byte;
    logic [15:0]       bus_page, bus_len;
    logic              bus_ready = 1'b0;
    logic              bus_err = 1'b0;
    logic [3:0]        bus_err_code = 4'h0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [42:0] exp_q [$];
    int          item_idx = 0;
    int          wait_cnt = 0;
    int          err_at = -1;
    logic [3:0]  err_code_drv = 4'h0;
    int          txn = 0;
    logic [42:0] seen;
    int          pushed = 0;

    rr_cmd_seq #(.NREGS(NREGS), .NMODES(NMODES), .MODE_W(MODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_flow(req_flow),
        .req_mode(req_mode), .req_otp_sel(req_otp_sel), .busy(busy), .done(done),
        .done_err(done_err), .done_code(done_code), .bus_valid(bus_valid),
        .bus_kind(bus_kind), .bus_byte(bus_byte), .bus_page(bus_page),
        .bus_len(bus_len), .bus_ready(bus_ready), .bus_err(bus_err),
        .bus_err_code(bus_err_code)
    );

    always #10 clk = ~clk;

    function automatic logic [42:0] mk(input int k, input logic [7:0] b,
                                       input logic [15:0] p, input logic [15:0] l);
        return {3'(k), b, p, l};
    endfunction

    function automatic logic [7:0] exp_off(input int i);
        logic [7:0] t [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
        return t[i];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Queue one expected item unless the error cut already passed.
    task automatic push(input logic [42:0] it);
        if (err_at < 0 || pushed <= err_at) exp_q.push_back(it);
        pushed++;
    endtask

    // Bus model: stalls, compares on acceptance, injects errors.
    always @(negedge clk) begin
        cycles++;
        bus_ready = 1'b0;
        bus_err = 1'b0;
        bus_err_code = 4'h0;
        if (rst_n && bus_valid) begin
            if (wait_cnt == 0) seen = {bus_kind, bus_byte, bus_page, bus_len};
            if (wait_cnt < (item_idx + txn) % 3) begin
                wait_cnt++;
            end else begin
                // R7: cycle content unchanged while stalled
                check({bus_kind, bus_byte, bus_page, bus_len} == seen, "R7", "hold",
                      64'({bus_kind, bus_byte, bus_page, bus_len}), 64'(seen));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected cycle",
                          64'({bus_kind, bus_byte, bus_page, bus_len}), 64'h0);
                end else begin
                    logic [42:0] e;
                    e = exp_q.pop_front();
                    check({bus_kind, bus_byte, bus_page, bus_len} == e, "R1-item", "cycle",
                          64'({bus_kind, bus_byte, bus_page, bus_len}), 64'(e));
                end
                bus_ready = 1'b1;
                if (item_idx == err_at) begin
                    bus_err = 1'b1;
                    bus_err_code = err_code_drv;
                end
                item_idx++;
                wait_cnt = 0;
            end
        end
    end

    // Watchdog.
    always @(negedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: queue expectations, start, wait for done, check status.
    task automatic run(input bit flow, input int mode, input bit sel, input int e_at,
                       input logic [3:0] e_code, input bit poke, input string req);
        bit bad;
        int n;
        bit exp_err;
        logic [3:0] exp_code;
        @(negedge clk);
        txn++;
        item_idx = 0;
        wait_cnt = 0;
        err_at = e_at;
        err_code_drv = e_code;
        pushed = 0;
        bad = !flow && (mode >= NMODES);
        if (!bad && !flow) begin
            push(mk(0, 8'h36, 0, 0));                         // R1
            for (int i = 0; i < NREGS; i++) begin
                push(mk(1, exp_off(i), 0, 0));                // R2
                push(mk(2, 8'(((mode * 16) + i) ^ 8'hA5), 0, 0)); // R3
            end
            push(mk(0, 8'h16, 0, 0));
        end else if (flow) begin
            push(mk(4, 8'hFF, 0, 0));                         // R4
            push(mk(0, 8'h36, 0, 0));
            push(mk(1, 8'h38, 0, 0));
            push(mk(2, 8'h52, 0, 0));
            push(mk(0, 8'h16, 0, 0));
            push(mk(0, 8'h17, 0, 0));
            push(mk(0, 8'h04, 0, 0));
            push(mk(0, 8'h19, 0, 0));
            push(sel ? mk(3, 0, 16'h0200, 16'd528) : mk(3, 0, 16'h021F, 16'd784)); // R5
            push(mk(4, 8'hFF, 0, 0));                         // R6
            push(mk(0, 8'h36, 0, 0));
            push(mk(1, 8'h38, 0, 0));
            push(mk(2, 8'h00, 0, 0));
            push(mk(0, 8'h16, 0, 0));
            push(mk(3, 0, 0, 0));
        end
        exp_err = bad || (e_at >= 0);
        exp_code = bad ? 4'hF : ((e_at >= 0) ? e_code : 4'h0);
        req_flow = flow;
        req_mode = MODE_W'(mode);
        req_otp_sel = sel;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (bad) begin
            // R11: done in the cycle after start, no cycles
            check(done && !busy && !bus_valid, "R11", "reject", {61'h0, done, busy, bus_valid}, 64'h4);
        end else begin
            check(busy, "R9", "busy after start", 64'(busy), 64'h1);
            n = 0;
            while (!done && n < 1000) begin
                if (poke && n == 4) begin
                    req_flow = !flow;   // R10: start while busy
                    req_mode = '0;
                    req_start = 1'b1;
                end else begin
                    req_start = 1'b0;
                end
                check(busy, "R9", "busy until done", 64'(busy), 64'h1);
                @(negedge clk);
                n++;
            end
            req_start = 1'b0;
            check(done && !busy, "R9", "done pulse without busy", {62'h0, done, busy}, 64'h2);
        end
        check(done_err == exp_err, exp_err ? "R8" : "R9", "done_err", 64'(done_err), 64'(exp_err));
        check(done_code == exp_code, "R8", "done_code", 64'(done_code), 64'(exp_code));
        check(exp_q.size() == 0, "R1", "missing cycles", 64'(exp_q.size()), 64'h0);
        @(negedge clk);
        check(!done && !busy && !bus_valid, "R9", "pulse ends",
              {61'h0, done, busy, bus_valid}, 64'h0);
        repeat (3) begin
            @(negedge clk);
            // R10 / R8: nothing follows the finished flow
            check(!bus_valid, "R10", "idle after flow", 64'(bus_valid), 64'h0);
        end
        exp_q.delete();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R12: reset state
        check(!busy && !done && !bus_valid, "R12", "in reset", {61'h0, busy, done, bus_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !bus_valid, "R12", "after reset", {61'h0, busy, done, bus_valid}, 64'h0);

        run(1'b0, 0, 1'b0, -1, 4'h0, 1'b0, "R1");
        run(1'b0, 3, 1'b0, -1, 4'h0, 1'b0, "R3");
        run(1'b0, 5, 1'b0, -1, 4'h0, 1'b0, "R3");
        run(1'b1, 0, 1'b0, -1, 4'h0, 1'b0, "R5");
        run(1'b1, 0, 1'b1, -1, 4'h0, 1'b0, "R6");
        run(1'b0, 6, 1'b0, -1, 4'h0, 1'b0, "R11");
        run(1'b0, 7, 1'b0, -1, 4'h0, 1'b0, "R11");
        run(1'b0, 2, 1'b0, 3, 4'h5, 1'b0, "R8");
        run(1'b1, 0, 1'b0, 0, 4'h9, 1'b0, "R8");
        run(1'b1, 0, 1'b1, 14, 4'h3, 1'b0, "R8");
        run(1'b0, 1, 1'b0, -1, 4'h0, 1'b1, "R10");
        run(1'b1, 0, 1'b1, -1, 4'h0, 1'b1, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule